// File: doc/BRIEF.md
# Multi-mode VGA raster timing generator

This block produces the raster timing for a VGA monitor from a 100 MHz system clock. A two-bit divider makes a pixel enable once every four system clocks, which gives a 25 MHz pixel rate. A horizontal counter steps on each pixel enable. A vertical counter steps each time the horizontal counter wraps. Sync pulses and the visible-area flag are decoded from the two counter values. The counters are also brought out as the current pixel column and line, so that a pixel source can use them as coordinates.

Three resolution timing sets are built in. Each set is stored as four cumulative end points per axis: the last visible count, the last front-porch count, the last sync count and the last back-porch count, after which the counter wraps. The sets are top-level parameters, so a bench or another instance can supply shorter rasters. A mode input picks the set at run time. The choice is only taken up when a frame ends.

In the visible area the block drives every pixel with one colour, taken from twelve switch inputs. Outside the visible area the colour output is black.

Top module: `vga_mode_timing_gen`

## Requirements
- R1: The pixel enable occurs once every 4 system clocks. After reset is released, the counters first step on the 4th rising edge, and then on every 4th edge after that.
- R2: `pix_x` counts up by one on each pixel enable. When it equals the horizontal back-porch end of the active set, it wraps to 0 on the next enable. It does not change without an enable.
- R3: `pix_y` steps by one only on the enable where `pix_x` wraps. After the vertical back-porch end it wraps to 0. At all other times it holds.
- R4: `mode_sel` encodes the timing set. Each set is listed as horizontal then vertical end points, each in the order visible, front porch, sync, back porch.
  - 0 selects 639, 655, 751, 799 and 479, 489, 491, 524.
  - 1 selects 799, 839, 967, 1055 and 599, 600, 604, 627.
  - 2 selects 1279, 1327, 1439, 1687 and 1023, 1026, 1031, 1073.
  - 3 behaves as 0.
- R5: The horizontal pulse is on when `pix_x` is greater than the front-porch end and not greater than the sync end. The vertical pulse uses `pix_y` the same way. Set 0 drives both pins low for "on". Sets 1 and 2 drive both pins high for "on".
- R6: `active_video` is 1 exactly when `pix_x` is at or below the horizontal visible end and `pix_y` is at or below the vertical visible end.
- R7: While `active_video` is 1, `red` = `sw_color[11:8]`, `green` = `sw_color[7:4]` and `blue` = `sw_color[3:0]`. Otherwise all three are 0.
- R8: `mode_sel` is sampled only on the enable where both counters wrap together (end of frame). At any other time, a change on `mode_sel` has no effect on the timing.
- R9: While the synchronous, active-high `rst` is high, the following hold:
  - the divider and both counters are 0;
  - both sync pins sit at their "off" level;
  - the set named by `mode_sel` is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Timing set request, taken up at end of frame |
| sw_color | input | 12 | Fill colour, red in the top nibble, blue in the bottom |
| hsync | output | 1 | Horizontal sync pin, polarity set by the mode |
| vsync | output | 1 | Vertical sync pin, polarity set by the mode |
| active_video | output | 1 | High inside the visible area |
| red | output | 4 | Red level |
| green | output | 4 | Green level |
| blue | output | 4 | Blue level |
| pix_x | output | 11 | Current horizontal count |
| pix_y | output | 11 | Current line count |

## Verification
All outputs are decoded from the registered divider, counter and mode state, so each result is due in the same cycle as the rising edge that updates that state. No extra register delay applies. A counter step is therefore visible right after the 4th edge following reset release, and right after every 4th edge from then on. A new set becomes visible right after the edge on which the frame wraps. The bench advances its own model on every rising edge and compares every output at the following falling edge, so each expected value is checked against the cycle in which it is due. A second instance with very short parameter rasters lets whole frames, vertical pulses and deferred mode changes occur many times within the run.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;
  parameter int CNT_W   = 11;
  parameter int MODE_W  = 2;
  parameter int COLOR_W = 4;
  parameter int DIV_W   = 2;
  localparam int RGB_W  = 3 * COLOR_W;

  // Cumulative end points per axis, plus the sync polarity (1 = pins low when on).
  typedef struct packed {
    logic [CNT_W-1:0] h_act;
    logic [CNT_W-1:0] h_fp;
    logic [CNT_W-1:0] h_sync;
    logic [CNT_W-1:0] h_bp;
    logic [CNT_W-1:0] v_act;
    logic [CNT_W-1:0] v_fp;
    logic [CNT_W-1:0] v_sync;
    logic [CNT_W-1:0] v_bp;
    logic             sync_neg;
  } timing_t;

  localparam timing_t TIMING_640 = '{h_act: 11'd639, h_fp: 11'd655, h_sync: 11'd751, h_bp: 11'd799,
                                     v_act: 11'd479, v_fp: 11'd489, v_sync: 11'd491, v_bp: 11'd524,
                                     sync_neg: 1'b1};
  localparam timing_t TIMING_800 = '{h_act: 11'd799, h_fp: 11'd839, h_sync: 11'd967, h_bp: 11'd1055,
                                     v_act: 11'd599, v_fp: 11'd600, v_sync: 11'd604, v_bp: 11'd627,
                                     sync_neg: 1'b0};
  localparam timing_t TIMING_1280 = '{h_act: 11'd1279, h_fp: 11'd1327, h_sync: 11'd1439, h_bp: 11'd1687,
                                      v_act: 11'd1023, v_fp: 11'd1026, v_sync: 11'd1031, v_bp: 11'd1073,
                                      sync_neg: 1'b0};

  // Pulse window: strictly past the porch end, up to and including the sync end.
  function automatic logic in_pulse(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] porch_end,
                                    input logic [CNT_W-1:0] pulse_end);
    return (c > porch_end) && (c <= pulse_end);
  endfunction

  function automatic logic in_visible(input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] vis_end);
    return c <= vis_end;
  endfunction

  // Channel 0 is red (top nibble), 1 green, 2 blue.
  function automatic logic [COLOR_W-1:0] channel_of(input logic [RGB_W-1:0] sw, input int idx);
    return sw[(2 - idx) * COLOR_W +: COLOR_W];
  endfunction
endpackage

// File: rtl/vga_tg_pixdiv.sv
module vga_tg_pixdiv #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  assign tick = &phase;

  // R1: an enable is never followed directly by another one
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/vga_tg_axis.sv
module vga_tg_axis #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_end;

  assign at_end = (cnt >= last);
  assign wrap   = step && at_end;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R2/R3: the count holds between steps
  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(cnt));
  // R2/R3: reaching the last value and stepping returns to zero
  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst) (step && cnt == last) |=> cnt == '0);
endmodule

// File: rtl/vga_mode_timing_gen.sv
module vga_mode_timing_gen
  import vga_tg_pkg::*;
#(
  parameter timing_t MODE0_T = TIMING_640,
  parameter timing_t MODE1_T = TIMING_800,
  parameter timing_t MODE2_T = TIMING_1280
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic [RGB_W-1:0]   sw_color,
  output logic               hsync,
  output logic               vsync,
  output logic               active_video,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic [CNT_W-1:0]   pix_x,
  output logic [CNT_W-1:0]   pix_y
);
  logic              pix_tick, h_wrap, v_wrap, frame_end;
  logic              hs_on, vs_on;
  logic [MODE_W-1:0] mode_q;
  timing_t           cur;
  logic [COLOR_W-1:0] chan [3];

  function automatic timing_t lookup(input logic [MODE_W-1:0] m);
    case (m)
      2'd1:    return MODE1_T;
      2'd2:    return MODE2_T;
      default: return MODE0_T;
    endcase
  endfunction

  always_comb cur = lookup(mode_q);

  vga_tg_pixdiv #(.DIV_W(DIV_W)) u_div (.clk(clk), .rst(rst), .tick(pix_tick));

  vga_tg_axis #(.W(CNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .step(pix_tick), .last(cur.h_bp), .cnt(pix_x), .wrap(h_wrap));

  vga_tg_axis #(.W(CNT_W)) u_vcnt (
    .clk(clk), .rst(rst), .step(h_wrap), .last(cur.v_bp), .cnt(pix_y), .wrap(v_wrap));

  assign frame_end = v_wrap;

  // Mode is only taken up on reset or when the frame wraps.
  always_ff @(posedge clk) begin
    if (rst)            mode_q <= mode_sel;
    else if (frame_end) mode_q <= mode_sel;
  end

  assign hs_on        = in_pulse(pix_x, cur.h_fp, cur.h_sync);
  assign vs_on        = in_pulse(pix_y, cur.v_fp, cur.v_sync);
  assign hsync        = hs_on ^ cur.sync_neg;
  assign vsync        = vs_on ^ cur.sync_neg;
  assign active_video = in_visible(pix_x, cur.h_act) && in_visible(pix_y, cur.v_act);

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign chan[c] = active_video ? channel_of(sw_color, c) : '0;
  end

  assign red   = chan[0];
  assign green = chan[1];
  assign blue  = chan[2];

  // R3: the line count moves only when the pixel count wraps
  assert_line_step_R3: assert property (@(posedge clk) disable iff (rst) !h_wrap |=> $stable(pix_y));
  // R8: the mode is held for the whole frame
  assert_mode_frame_R8: assert property (@(posedge clk) disable iff (rst) !frame_end |=> $stable(mode_q));
  // R5: a horizontal pulse never overlaps the visible area
  assert_sync_blank_R5: assert property (@(posedge clk) disable iff (rst) hs_on |-> !active_video);
  // R6: the visible area starts at column zero
  assert_vis_start_R6: assert property (@(posedge clk) disable iff (rst) $rose(active_video) |-> pix_x == '0);
endmodule

// File: tb/vga_mode_timing_gen_tb.sv
`timescale 1ns/1ps
module vga_mode_timing_gen_tb;
  import vga_tg_pkg::*;

  // Short rasters for the second instance (same field order as the type).
  localparam timing_t S0 = '{h_act: 11'd7, h_fp: 11'd9, h_sync: 11'd11, h_bp: 11'd13,
                             v_act: 11'd3, v_fp: 11'd4, v_sync: 11'd6, v_bp: 11'd7, sync_neg: 1'b1};
  localparam timing_t S1 = '{h_act: 11'd4, h_fp: 11'd5, h_sync: 11'd7, h_bp: 11'd9,
                             v_act: 11'd2, v_fp: 11'd3, v_sync: 11'd4, v_bp: 11'd5, sync_neg: 1'b0};
  localparam timing_t S2 = '{h_act: 11'd9, h_fp: 11'd10, h_sync: 11'd12, h_bp: 11'd15,
                             v_act: 11'd5, v_fp: 11'd7, v_sync: 11'd8, v_bp: 11'd9, sync_neg: 1'b0};

  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  mode_sel = 0;
  logic [11:0] sw = 12'hA5C;

  logic        hs0, vs0, av0, hs1, vs1, av1;
  logic [3:0]  r0, g0, b0, r1, g1, b1;
  logic [10:0] x0, y0, x1, y1;

  int errors = 0, checks = 0;
  bit started = 0, done = 0;
  int m_div = 0;
  int m_h[2], m_v[2], m_mode[2];

  always #5 clk = ~clk;

  vga_mode_timing_gen u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sw_color(sw), .hsync(hs0), .vsync(vs0),
    .active_video(av0), .red(r0), .green(g0), .blue(b0), .pix_x(x0), .pix_y(y0));

  vga_mode_timing_gen #(.MODE0_T(S0), .MODE1_T(S1), .MODE2_T(S2)) u_small (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sw_color(sw), .hsync(hs1), .vsync(vs1),
    .active_video(av1), .red(r1), .green(g1), .blue(b1), .pix_x(x1), .pix_y(y1));

  // Timing end points from R4 (and the short sets); idx 0..3 horizontal, 4..7 vertical, 8 polarity.
  function automatic int lim(int s, int mode, int idx);
    int m = (mode == 1) ? 1 : (mode == 2) ? 2 : 0;
    int t[9];
    if (s == 0) begin
      case (m)
        1: t = '{799, 839, 967, 1055, 599, 600, 604, 627, 0};
        2: t = '{1279, 1327, 1439, 1687, 1023, 1026, 1031, 1073, 0};
        default: t = '{639, 655, 751, 799, 479, 489, 491, 524, 1};
      endcase
    end else begin
      case (m)
        1: t = '{4, 5, 7, 9, 2, 3, 4, 5, 0};
        2: t = '{9, 10, 12, 15, 5, 7, 8, 9, 0};
        default: t = '{7, 9, 11, 13, 3, 4, 6, 7, 1};
      endcase
    end
    return t[idx];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference raster model, advanced on each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0;
      for (int s = 0; s < 2; s++) begin m_h[s] = 0; m_v[s] = 0; m_mode[s] = mode_sel; end
    end else begin
      if (m_div == 3) begin
        for (int s = 0; s < 2; s++) begin
          if (m_h[s] == lim(s, m_mode[s], 3)) begin
            m_h[s] = 0;
            if (m_v[s] == lim(s, m_mode[s], 7)) begin m_v[s] = 0; m_mode[s] = mode_sel; end
            else m_v[s] = m_v[s] + 1;
          end else m_h[s] = m_h[s] + 1;
        end
      end
      m_div = (m_div + 1) % 4;
    end
    started = 1;
  end

  task automatic check_dut(int s, logic [10:0] px, logic [10:0] py, logic hs, logic vs, logic av,
                           logic [3:0] r, logic [3:0] g, logic [3:0] b);
    int md = m_mode[s];
    int h = m_h[s], v = m_v[s];
    int neg = lim(s, md, 8);
    int hon = (h > lim(s, md, 1)) && (h <= lim(s, md, 2));
    int von = (v > lim(s, md, 5)) && (v <= lim(s, md, 6));
    int vis = (h <= lim(s, md, 0)) && (v <= lim(s, md, 4));
    chk(rst ? "R9 pix_x in reset" : "R2 pix_x (set R4, deferral R8)", px, h);
    chk(rst ? "R9 pix_y in reset" : "R3 pix_y (deferral R8)", py, v);
    chk(rst ? "R9 hsync off in reset" : "R5 hsync", hs, hon ^ neg);
    chk(rst ? "R9 vsync off in reset" : "R5 vsync", vs, von ^ neg);
    chk("R6 active_video", av, vis);
    chk("R7 red", r, vis ? int'(sw[11:8]) : 0);
    chk("R7 green", g, vis ? int'(sw[7:4]) : 0);
    chk("R7 blue", b, vis ? int'(sw[3:0]) : 0);
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check_dut(0, x0, y0, hs0, vs0, av0, r0, g0, b0);
      check_dut(1, x1, y1, hs1, vs1, av1, r1, g1, b1);
    end
  end

  task automatic run(int n, bit wander);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wander && ($urandom % 61 == 0)) mode_sel = 2'($urandom % 4);
      if ($urandom % 45 == 0) sw = 12'($urandom);
    end
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst = 1;
    mode_sel = 2'(mode);
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state, with set 0 (active-low pins)
    repeat (3) @(negedge clk);
    chk("R9 reset pix_x", x0, 0);
    chk("R9 reset hsync level (set 0 off = 1)", hs0, 1);
    chk("R9 reset vsync level (set 0 off = 1)", vs0, 1);
    rst = 0;
    // R1: the first step lands on the 4th rising edge after release
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R1 no step before 4th edge", x0, 0);
    end
    @(negedge clk);
    chk("R1 step at 4th edge", x0, 1);
    chk("R1 step at 4th edge (short raster)", x1, 1);
    repeat (4) @(negedge clk);
    chk("R1 second step 4 edges later", x0, 2);

    // Set 0 on the full-size instance, mode input wandering (R8: no effect mid-frame)
    run(13000, 1);
    chk("R8 full-size set still 0", lim(0, m_mode[0], 3), 799);

    // R9 + R4: reset with set 1, pins idle low
    do_reset(1);
    @(negedge clk);
    chk("R9 reset hsync level (set 1 off = 0)", hs0, 0);
    run(9000, 0);
    do_reset(2);
    run(14000, 0);
    do_reset(3);
    run(4000, 0);

    // Long random phase: short raster completes many frames and picks up mode changes
    do_reset(0);
    run(40000, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule